// File: doc/BRIEF.md
# Raster Sync and Blanking Generator

This block produces the line and frame timing for a 640x480, 60 Hz analog display raster. A free-running divider turns a system clock that runs at an integer multiple of the pixel rate into a one-cycle pixel strobe. A column counter and a row counter step on that strobe and walk through the visible area, then the front porch, the sync pulse and the back porch, first across each line and then across each frame.

From those counts the block derives three signals: a horizontal sync, a vertical sync, and a flag that marks the visible window. It also passes an upstream pixel colour through to its output, and forces that colour to black everywhere outside the visible window, including both porches and both sync pulses.

All outputs leave the block from registers in the same stage, so they stay aligned with one another. Every length is a parameter: the visible width and height, each porch, each sync pulse, the clock-to-pixel ratio and the sync polarity.

Top module: `scan_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counters and the divider are cleared, both syncs take their idle level (high with the default active-low polarity), and `active` and `rgb_out` are zero.
- R2: The pixel position advances exactly once every `CLK_DIV` clock cycles. After the edge at which reset is released, the first position is shown for `CLK_DIV` cycles.
- R3: Each line is `H_VIS + H_FP + H_SYNC + H_BP` positions long. `col` counts up from 0 to the last position and then returns to 0.
- R4: `hsync` is at its asserted level (low by default) exactly while the column lies in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC-1]. With the default parameters that is [656, 751].
- R5: The row advances only when the column wraps from its last value to 0. Each frame is `V_VIS + V_FP + V_SYNC + V_BP` rows long. `vsync` is asserted exactly while the row lies in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC-1], which is [490, 491] by default.
- R6: `active` is high exactly when the column is below `H_VIS` and the row is below `V_VIS`. While `active` is high, `col` and `row` give the visible pixel position.
- R7: While `active` is high, `rgb_out` equals `rgb_in`. At every other position, including the porches and the sync pulses, `rgb_out` is zero.
- R8: `hsync`, `vsync`, `active`, `col`, `row` and `rgb_out` all show the state present one clock cycle earlier: the counter values and the `rgb_in` that were present at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, an integer multiple of the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| rgb_in | input | RGB_W | Pixel colour from the upstream source |
| hsync | output | 1 | Line sync, polarity set by SYNC_LOW |
| vsync | output | 1 | Frame sync, polarity set by SYNC_LOW |
| active | output | 1 | High inside the visible window |
| col | output | COL_W | Current column |
| row | output | ROW_W | Current row |
| rgb_out | output | RGB_W | Colour, forced to zero outside the visible window |

## Verification
The assertions assume two things about the inputs: reset is high at the first clock edge, and the parameters describe a line and a frame longer than their visible parts. They make no assumption about `rgb_in`. The stimulus holds reset for three edges before releasing it, and uses only default or hand-checked small timings. It changes `rgb_in` at every cycle, so any skew between the colour and the window flag shows up.

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int CLK_DIV  = 1,
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter bit SYNC_LOW = 1'b1,
  parameter int RGB_W    = 12,
  parameter int COL_W    = $clog2(H_VIS + H_FP + H_SYNC + H_BP),
  parameter int ROW_W    = $clog2(V_VIS + V_FP + V_SYNC + V_BP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RGB_W-1:0] rgb_in,
  output logic             hsync,
  output logic             vsync,
  output logic             active,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic [RGB_W-1:0] rgb_out
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int H_SS  = H_VIS + H_FP;
  localparam int H_SE  = H_SS + H_SYNC;
  localparam int V_SS  = V_VIS + V_FP;
  localparam int V_SE  = V_SS + V_SYNC;
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0] div;
  logic [COL_W-1:0] hc;
  logic [ROW_W-1:0] vc;

  wire tick  = (div == DIV_W'(CLK_DIV - 1));
  wire h_end = (hc == COL_W'(H_TOT - 1));
  wire v_end = (vc == ROW_W'(V_TOT - 1));
  wire vis   = (hc < COL_W'(H_VIS)) && (vc < ROW_W'(V_VIS));
  wire h_in  = (hc >= COL_W'(H_SS)) && (hc < COL_W'(H_SE));
  wire v_in  = (vc >= ROW_W'(V_SS)) && (vc < ROW_W'(V_SE));

  always_ff @(posedge clk) begin
    if (rst) begin
      div <= '0;
      hc  <= '0;
      vc  <= '0;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        hc <= h_end ? '0 : hc + 1'b1;
        if (h_end) vc <= v_end ? '0 : vc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync   <= SYNC_LOW;
      vsync   <= SYNC_LOW;
      active  <= 1'b0;
      col     <= '0;
      row     <= '0;
      rgb_out <= '0;
    end else begin
      hsync   <= h_in ^ SYNC_LOW;
      vsync   <= v_in ^ SYNC_LOW;
      active  <= vis;
      col     <= hc;
      row     <= vc;
      rgb_out <= vis ? rgb_in : '0;
    end
  end
endmodule

// File: rtl/scan_timer_chk.sv
module scan_timer_chk #(
  parameter int H_VIS    = 640,
  parameter int V_VIS    = 480,
  parameter int H_TOT    = 800,
  parameter int H_SS     = 656,
  parameter int H_SE     = 752,
  parameter bit SYNC_LOW = 1'b1,
  parameter int RGB_W    = 12,
  parameter int COL_W    = 10,
  parameter int ROW_W    = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             hsync,
  input logic             vsync,
  input logic             active,
  input logic [COL_W-1:0] col,
  input logic [ROW_W-1:0] row,
  input logic [RGB_W-1:0] rgb_out
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (hsync == SYNC_LOW && vsync == SYNC_LOW && !active && rgb_out == '0));

  assert_col_step_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(col) |-> (int'(col) == int'($past(col)) + 1 ||
                       (col == '0 && int'($past(col)) == H_TOT - 1)));

  assert_hsync_window_R4: assert property (@(posedge clk) disable iff (rst)
    (hsync != SYNC_LOW) == (int'(col) >= H_SS && int'(col) < H_SE));

  assert_row_on_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(row) |-> (int'($past(col)) == H_TOT - 1 && col == '0));

  assert_active_bounds_R6: assert property (@(posedge clk) disable iff (rst)
    active |-> (int'(col) < H_VIS && int'(row) < V_VIS));

  assert_black_outside_R7: assert property (@(posedge clk) disable iff (rst)
    !active |-> rgb_out == '0);
endmodule

bind scan_timer scan_timer_chk #(
  .H_VIS(H_VIS), .V_VIS(V_VIS), .H_TOT(H_TOT), .H_SS(H_SS), .H_SE(H_SE),
  .SYNC_LOW(SYNC_LOW), .RGB_W(RGB_W), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .active(active),
  .col(col), .row(row), .rgb_out(rgb_out)
);

// File: tb/sim_scan_timer.sv
module sim_scan_timer;
  localparam int CLK_P = 10;
  localparam int N0 = 2, HV0 = 8, HF0 = 2, HS0 = 3, HB0 = 2;
  localparam int VV0 = 4, VF0 = 1, VS0 = 2, VB0 = 1;
  localparam int HT0 = HV0 + HF0 + HS0 + HB0;
  localparam int VT0 = VV0 + VF0 + VS0 + VB0;
  localparam int CYC = 2500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] rgb = '0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic hs0, vs0, ac0;
  logic [3:0] col0;
  logic [2:0] row0;
  logic [11:0] rgb0;
  logic hs1, vs1, ac1;
  logic [9:0] col1, row1;
  logic [11:0] rgb1;

  always #(CLK_P/2) clk = ~clk;

  scan_timer #(.CLK_DIV(N0), .H_VIS(HV0), .H_FP(HF0), .H_SYNC(HS0), .H_BP(HB0),
               .V_VIS(VV0), .V_FP(VF0), .V_SYNC(VS0), .V_BP(VB0)) u0 (
    .clk(clk), .rst(rst), .rgb_in(rgb), .hsync(hs0), .vsync(vs0), .active(ac0),
    .col(col0), .row(row0), .rgb_out(rgb0));

  scan_timer u1 (
    .clk(clk), .rst(rst), .rgb_in(rgb), .hsync(hs1), .vsync(vs1), .active(ac1),
    .col(col1), .row(row1), .rgb_out(rgb1));

  function automatic logic [11:0] pat(int t);
    return 12'((t * 173) ^ (t >> 3) ^ 12'hA5C);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 300000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state on both instances
    chk(hs0 == 1'b1 && vs0 == 1'b1, "R1 sync idle", {hs0, vs0}, 3);
    chk(ac0 == 1'b0 && rgb0 == '0, "R1 active/rgb", int'(rgb0) + ac0, 0);
    chk(hs1 == 1'b1 && vs1 == 1'b1 && ac1 == 1'b0, "R1 u1 idle", {hs1, vs1, ac1}, 6);
    rst = 1'b0;
    rgb = pat(1);
    for (int t = 1; t <= CYC; t++) begin
      @(negedge clk);
      begin
        int p, h, v, p1, h1, v1;
        bit ea, eh, ev, ea1;
        // R2 + R8: pixel index one cycle behind the edge count
        p  = (t - 1) / N0;
        h  = p % HT0;
        v  = (p / HT0) % VT0;
        ea = (h < HV0) && (v < VV0);
        eh = (h >= HV0 + HF0) && (h < HV0 + HF0 + HS0);
        ev = (v >= VV0 + VF0) && (v < VV0 + VF0 + VS0);
        chk(int'(col0) == h, "R2/R3 col", col0, h);
        chk(int'(row0) == v, "R5 row", row0, v);
        chk(hs0 == !eh, "R4 hsync", hs0, !eh);
        chk(vs0 == !ev, "R5 vsync", vs0, !ev);
        chk(ac0 == ea, "R6 active", ac0, ea);
        chk(rgb0 == (ea ? pat(t) : 12'd0), "R7/R8 rgb", rgb0, ea ? pat(t) : 0);
        // default timing, one clock per pixel
        p1  = t - 1;
        h1  = p1 % 800;
        v1  = p1 / 800;
        ea1 = (h1 < 640);
        chk(int'(col1) == h1, "R3 u1 col", col1, h1);
        chk(int'(row1) == v1, "R5 u1 row", row1, v1);
        chk(hs1 == !(h1 >= 656 && h1 <= 751), "R4 u1 hsync", hs1, !(h1 >= 656 && h1 <= 751));
        chk(vs1 == 1'b1, "R5 u1 vsync", vs1, 1);
        chk(ac1 == ea1, "R6 u1 active", ac1, ea1);
        chk(rgb1 == (ea1 ? pat(t) : 12'd0), "R7 u1 rgb", rgb1, ea1 ? pat(t) : 0);
      end
      rgb = pat(t + 1);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule